// File: doc/BRIEF.md
# High-Side Switch Protection Controller

This block holds the digital enable and diagnostic logic for one high-side load switch. A direct enable input requests the switch. Comparator flags for overcurrent, underload, over-temperature (a trip flag and a separate recovery flag), supply overvoltage and an active system reset come in already digitised. From these the block drives the switch-gate request and an active-low diagnostic output. The analog current sensing, current limiting and slew control are outside the block.

Each fault has its own response. Overcurrent, over-temperature, overvoltage and reset force the gate off and pull the diagnostic low. Underload only pulls the diagnostic low. Every fault has its own filter and its own release rule. The underload check is blanked for a time after each turn-on. The turn-on delay depends on how long the enable was low before it rose. All times are parameters counted in clock cycles.

Top module: `hsw_protect`

## Requirements
- R1: While the enable was sampled low at the last edge, `gateOn` is 0 and `diagN` is 1. With the enable high and no fault present, `gateOn` is 1 once the turn-on delay has passed, and `diagN` stays 1 throughout.
- R2: If `ocFlag` is sampled high on OC_FILT consecutive edges while the gate is on, the gate turns off and `diagN` goes low. Fewer consecutive edges have no effect. The fault stays latched until the enable is sampled low.
- R3: Underload is evaluated only after the gate has been on for UL_BLANK edges. If `ulFlag` is then sampled high on UL_FILT consecutive edges, `diagN` goes low and the gate stays on. The first edge that samples `ulFlag` low clears the flag.
- R4: An edge that samples `otHot` high turns the gate off and pulls `diagN` low. The fault holds until an edge samples `otCool` high with `otHot` low.
- R5: If `ovFlag` is sampled high on OV_FILT consecutive edges, the gate turns off and `diagN` goes low. The first edge that samples `ovFlag` low clears the fault.
- R6: While `resetActive` is sampled high and the enable is high, the gate is off and `diagN` is low. After release, the gate returns on the next edge.
- R7: If the enable was low on fewer than LONG_OFF edges before it rose, the gate turns on SHORT_DLY edges after the first edge that samples the enable high.
- R8: If the enable was low on LONG_OFF or more edges, the delay is LONG_DLY edges instead. The state just after reset counts as a long off time.
- R9: Any fault that forces the gate off takes priority over underload: the gate is off and `diagN` is low.
- R10: The underload blanking count restarts from zero every time the gate turns on.
- R11: If the enable drops during the turn-on delay, the delay is abandoned, the gate never turns on, and `diagN` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enIn | input | 1 | Direct switch enable |
| ocFlag | input | 1 | Overcurrent comparator flag |
| ulFlag | input | 1 | Underload comparator flag |
| otHot | input | 1 | Temperature above trip threshold |
| otCool | input | 1 | Temperature below recovery threshold |
| ovFlag | input | 1 | Supply overvoltage comparator flag |
| resetActive | input | 1 | System reset asserted |
| gateOn | output | 1 | Switch gate request |
| diagN | output | 1 | Active-low diagnostic |

## Verification
The hardest case to reach is an underload fault that overlaps an off-forcing fault right after a fresh turn-on. It needs the enable history, the delay, the full blanking window and the underload filter all lined up first. Directed sequences set up each of these in turn, with exact cycle counts for each delay, filter and blanking boundary. Seeded random stimulus then holds every flag for random lengths around the filter lengths. A cycle-level model in the bench predicts both outputs on every cycle.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } swState_t;

  typedef struct packed {
    logic loadDly;
    logic countDly;
    logic gateOn;
  } hswStrobe_t;
endpackage

// File: rtl/hsw_filter.sv
module hsw_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic hit
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] TOP = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + CW'(1);
  end

  assign hit = run && (cnt == TOP);

  // Requirements R2, R3, R5: the counter only advances on consecutive run cycles
  p_filter_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0));
endmodule

// File: rtl/hsw_datapath.sv
module hsw_datapath
  import hsw_pkg::*;
#(
  parameter int OC_FILT   = 6,
  parameter int OV_FILT   = 10,
  parameter int UL_BLANK  = 12,
  parameter int UL_FILT   = 7,
  parameter int LONG_OFF  = 20,
  parameter int SHORT_DLY = 4,
  parameter int LONG_DLY  = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enIn,
  input  logic       ocFlag,
  input  logic       ovFlag,
  input  logic       ulFlag,
  input  hswStrobe_t strb,
  output logic       dlyZero,
  output logic       ocHit,
  output logic       ovHit,
  output logic       ulHit
);
  localparam int OW = $clog2(LONG_OFF + 1);
  localparam int DW = $clog2(LONG_DLY + 1);
  localparam int BW = $clog2(UL_BLANK + 1);
  localparam logic [OW-1:0] OFF_TOP   = OW'(LONG_OFF);
  localparam logic [DW-1:0] DLY_LONG  = DW'(LONG_DLY - 1);
  localparam logic [DW-1:0] DLY_SHORT = DW'(SHORT_DLY - 1);
  localparam logic [BW-1:0] BLANK_TOP = BW'(UL_BLANK);
  localparam int NFILT = 3;

  logic [OW-1:0] offCnt;
  logic [DW-1:0] dlyCnt;
  logic [BW-1:0] blankCnt;
  logic          offLong;
  logic          blankDone;
  logic [NFILT-1:0] runVec;
  logic [NFILT-1:0] hitVec;

  // enable-low duration, saturating; after reset counts as long
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                offCnt <= OFF_TOP;
    else if (enIn)            offCnt <= '0;
    else if (offCnt != OFF_TOP) offCnt <= offCnt + OW'(1);
  end
  assign offLong = (offCnt == OFF_TOP);

  // turn-on delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            dlyCnt <= '0;
    else if (strb.loadDly)                dlyCnt <= offLong ? DLY_LONG : DLY_SHORT;
    else if (strb.countDly && dlyCnt != '0) dlyCnt <= dlyCnt - DW'(1);
  end
  assign dlyZero = (dlyCnt == '0);

  // underload blanking, restarts whenever the gate is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     blankCnt <= '0;
    else if (!strb.gateOn)         blankCnt <= '0;
    else if (blankCnt != BLANK_TOP) blankCnt <= blankCnt + BW'(1);
  end
  assign blankDone = (blankCnt == BLANK_TOP);

  assign runVec = {strb.gateOn & blankDone & ulFlag,
                   ovFlag,
                   strb.gateOn & ocFlag};

  for (genvar i = 0; i < NFILT; i++) begin : g_filt
    localparam int LEN = (i == 0) ? OC_FILT : ((i == 1) ? OV_FILT : UL_FILT);
    hsw_filter #(.LEN(LEN)) u_filt (
      .clk  (clk),
      .rstN (rstN),
      .run  (runVec[i]),
      .hit  (hitVec[i])
    );
  end

  assign ocHit = hitVec[0];
  assign ovHit = hitVec[1];
  assign ulHit = hitVec[2];

  // R7 / R8: a delay load picks one of the two lengths
  p_delay_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDly |=> (dlyCnt == DLY_SHORT || dlyCnt == DLY_LONG));

  // R10: blanking starts from zero on every turn-on
  p_blank_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.gateOn) |-> (blankCnt == '0));

  // R3: no underload hit before blanking has elapsed
  p_ul_blanked_r3: assert property (@(posedge clk) disable iff (!rstN)
    ulHit |-> blankDone);
endmodule

// File: rtl/hsw_control.sv
module hsw_control
  import hsw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enIn,
  input  logic       ulFlag,
  input  logic       otHot,
  input  logic       otCool,
  input  logic       ovFlag,
  input  logic       resetActive,
  input  logic       dlyZero,
  input  logic       ocHit,
  input  logic       ovHit,
  input  logic       ulHit,
  output hswStrobe_t strb,
  output logic       gateOn,
  output logic       diagN
);
  swState_t state;
  logic ocLatch, otLatch, ovFault, ulFault, rstQ;
  logic offHold;

  assign offHold = ocLatch | otLatch | ovFault | rstQ;
  assign gateOn  = (state == ST_ON) && !offHold;
  assign diagN   = !((state != ST_IDLE) && (offHold || ulFault));

  assign strb.loadDly  = (state == ST_IDLE) && enIn;
  assign strb.countDly = (state == ST_WAIT);
  assign strb.gateOn   = gateOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (enIn) state <= ST_WAIT;
        ST_WAIT: if (!enIn) state <= ST_IDLE;
                 else if (dlyZero) state <= ST_ON;
        ST_ON:   if (!enIn) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocLatch <= 1'b0;
      otLatch <= 1'b0;
      ovFault <= 1'b0;
      ulFault <= 1'b0;
      rstQ    <= 1'b0;
    end else begin
      rstQ <= resetActive;
      if (!enIn)      ocLatch <= 1'b0;
      else if (ocHit) ocLatch <= 1'b1;
      if (otHot)       otLatch <= 1'b1;
      else if (otCool) otLatch <= 1'b0;
      if (!ovFlag)     ovFault <= 1'b0;
      else if (ovHit)  ovFault <= 1'b1;
      if (!gateOn || !ulFlag) ulFault <= 1'b0;
      else if (ulHit)         ulFault <= 1'b1;
    end
  end

  // R1: a low enable leaves the gate off
  p_gate_needs_enable_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> (!gateOn && diagN));

  // R2: a latched overcurrent holds the gate off while enabled
  p_oc_latched_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ocLatch && enIn) |=> (!gateOn && !diagN));

  // R4: over-temperature stays until recovery is seen
  p_ot_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (otLatch && !otCool) |=> otLatch);

  // R5: overvoltage releases as soon as the flag is low
  p_ov_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ovFlag |=> !ovFault);

  // R6: reset forces the gate off
  p_reset_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetActive |=> !gateOn);
endmodule

// File: rtl/hsw_protect.sv
module hsw_protect
  import hsw_pkg::*;
#(
  parameter int OC_FILT   = 6,
  parameter int OV_FILT   = 10,
  parameter int UL_BLANK  = 12,
  parameter int UL_FILT   = 7,
  parameter int LONG_OFF  = 20,
  parameter int SHORT_DLY = 4,
  parameter int LONG_DLY  = 14
) (
  input  logic clk,
  input  logic rstN,
  input  logic enIn,
  input  logic ocFlag,
  input  logic ulFlag,
  input  logic otHot,
  input  logic otCool,
  input  logic ovFlag,
  input  logic resetActive,
  output logic gateOn,
  output logic diagN
);
  hswStrobe_t strb;
  logic dlyZero, ocHit, ovHit, ulHit;

  hsw_datapath #(
    .OC_FILT(OC_FILT), .OV_FILT(OV_FILT), .UL_BLANK(UL_BLANK),
    .UL_FILT(UL_FILT), .LONG_OFF(LONG_OFF), .SHORT_DLY(SHORT_DLY),
    .LONG_DLY(LONG_DLY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .enIn(enIn), .ocFlag(ocFlag),
    .ovFlag(ovFlag), .ulFlag(ulFlag), .strb(strb),
    .dlyZero(dlyZero), .ocHit(ocHit), .ovHit(ovHit), .ulHit(ulHit)
  );

  hsw_control u_ctl (
    .clk(clk), .rstN(rstN), .enIn(enIn), .ulFlag(ulFlag),
    .otHot(otHot), .otCool(otCool), .ovFlag(ovFlag),
    .resetActive(resetActive), .dlyZero(dlyZero), .ocHit(ocHit),
    .ovHit(ovHit), .ulHit(ulHit), .strb(strb),
    .gateOn(gateOn), .diagN(diagN)
  );
endmodule

// File: tb/hsw_protect_bench.sv
module hsw_protect_bench;
  localparam int OC_FILT   = 6;
  localparam int OV_FILT   = 10;
  localparam int UL_BLANK  = 12;
  localparam int UL_FILT   = 7;
  localparam int LONG_OFF  = 20;
  localparam int SHORT_DLY = 4;
  localparam int LONG_DLY  = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 1'b0, ocFlag = 1'b0, ulFlag = 1'b0, otHot = 1'b0;
  logic otCool = 1'b0, ovFlag = 1'b0, resetActive = 1'b0;
  logic gateOn, diagN;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  hsw_protect #(
    .OC_FILT(OC_FILT), .OV_FILT(OV_FILT), .UL_BLANK(UL_BLANK),
    .UL_FILT(UL_FILT), .LONG_OFF(LONG_OFF), .SHORT_DLY(SHORT_DLY),
    .LONG_DLY(LONG_DLY)
  ) u_hsw_protect (
    .clk(clk), .rstN(rstN), .enIn(enIn), .ocFlag(ocFlag), .ulFlag(ulFlag),
    .otHot(otHot), .otCool(otCool), .ovFlag(ovFlag),
    .resetActive(resetActive), .gateOn(gateOn), .diagN(diagN)
  );

  // ---------------- reference model built from the requirements ----------------
  int mMode;      // 0 off, 1 delaying, 2 on
  int mLowRun, mDly, mOcRun, mOvRun, mOnRun, mUlRun;
  bit mOcL, mOt, mOv, mUl, mRst;

  function automatic bit modelGate();
    return (mMode == 2) && !(mOcL || mOt || mOv || mRst);
  endfunction

  function automatic bit modelDiag();
    return !((mMode != 0) && (mOcL || mOt || mOv || mRst || mUl));
  endfunction

  function automatic string modelTag();
    if (mMode == 0) return "R1";
    if (mRst) return "R6";
    if (mOcL) return "R2";
    if (mOt)  return "R4";
    if (mOv)  return "R5";
    if (mUl)  return "R3";
    if (mMode == 1) return "R7";
    return "R1";
  endfunction

  always @(posedge clk) begin
    bit g, blankOk;
    int nOc, nOv, nUl;
    if (!rstN) begin
      mMode = 0; mLowRun = LONG_OFF; mDly = 0; mOcRun = 0; mOvRun = 0;
      mOnRun = 0; mUlRun = 0; mOcL = 0; mOt = 0; mOv = 0; mUl = 0; mRst = 0;
    end else begin
      g = modelGate();
      blankOk = (mOnRun >= UL_BLANK);
      nOc = (g && ocFlag) ? mOcRun + 1 : 0;
      nOv = ovFlag ? mOvRun + 1 : 0;
      nUl = (g && blankOk && ulFlag) ? mUlRun + 1 : 0;
      case (mMode)
        0: if (enIn) begin
             mMode = 1;
             mDly = (mLowRun >= LONG_OFF) ? LONG_DLY - 1 : SHORT_DLY - 1;
           end
        1: if (!enIn) mMode = 0;
           else if (mDly == 0) mMode = 2;
           else mDly = mDly - 1;
        default: if (!enIn) mMode = 0;
      endcase
      mLowRun = enIn ? 0 : mLowRun + 1;
      if (!enIn) mOcL = 0; else if (nOc >= OC_FILT) mOcL = 1;
      if (otHot) mOt = 1; else if (otCool) mOt = 0;
      mOv = ovFlag && (mOv || nOv >= OV_FILT);
      if (!g || !ulFlag) mUl = 0; else if (nUl >= UL_FILT) mUl = 1;
      mRst = resetActive;
      mOnRun = g ? mOnRun + 1 : 0;
      mOcRun = nOc; mOvRun = nOv; mUlRun = nUl;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic report(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) begin
      report(modelTag(), "gateOn vs model", int'(gateOn), int'(modelGate()));
      report(modelTag(), "diagN vs model", int'(diagN), int'(modelDiag()));
    end
  endtask

  task automatic expectOut(bit g, bit d, string tag);
    report(tag, "gateOn", int'(gateOn), int'(g));
    report(tag, "diagN", int'(diagN), int'(d));
  endtask

  task automatic countOn(output int n);
    n = 0;
    do begin tick(); n++; end while (!gateOn && n < 200);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    int unsigned seed;
    int hEn, hOc, hUl, hOt, hCool, hOv, hRst;
    seed = $urandom(32'd7341);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    expectOut(1'b0, 1'b1, "R1");             // reset state

    // R8: first turn-on after reset uses the long delay
    enIn = 1'b1;
    countOn(n);
    report("R8", "delay after reset", n, LONG_DLY + 1);
    expectOut(1'b1, 1'b1, "R1");

    // R7: brief low time gives the short delay
    enIn = 1'b0; repeat (3) tick(); enIn = 1'b1;
    countOn(n);
    report("R7", "short delay", n, SHORT_DLY + 1);

    // R7 / R8 boundary on the low-time threshold
    enIn = 1'b0; repeat (LONG_OFF - 1) tick(); enIn = 1'b1;
    countOn(n);
    report("R7", "delay just under threshold", n, SHORT_DLY + 1);
    enIn = 1'b0; repeat (LONG_OFF) tick(); enIn = 1'b1;
    countOn(n);
    report("R8", "delay at threshold", n, LONG_DLY + 1);

    // R2: one cycle short of the filter is ignored, full filter latches
    ocFlag = 1'b1; repeat (OC_FILT - 1) tick();
    expectOut(1'b1, 1'b1, "R2");
    ocFlag = 1'b0; tick();
    expectOut(1'b1, 1'b1, "R2");
    ocFlag = 1'b1; repeat (OC_FILT) tick();
    expectOut(1'b0, 1'b0, "R2");
    ocFlag = 1'b0; repeat (5) tick();
    expectOut(1'b0, 1'b0, "R2");
    enIn = 1'b0; tick();
    expectOut(1'b0, 1'b1, "R1");
    enIn = 1'b1;
    countOn(n);
    report("R2", "recovery after enable low", n, SHORT_DLY + 1);

    // R4: trip, hold without recovery flag, release on recovery
    otHot = 1'b1; tick(); expectOut(1'b0, 1'b0, "R4");
    otHot = 1'b0; repeat (4) tick(); expectOut(1'b0, 1'b0, "R4");
    otCool = 1'b1; tick(); expectOut(1'b1, 1'b1, "R4");
    otCool = 1'b0;

    // R5: overvoltage filter and release
    ovFlag = 1'b1; repeat (OV_FILT - 1) tick(); expectOut(1'b1, 1'b1, "R5");
    tick(); expectOut(1'b0, 1'b0, "R5");
    ovFlag = 1'b0; tick(); expectOut(1'b1, 1'b1, "R5");

    // R6: reset forces off, resumes on release
    resetActive = 1'b1; tick(); expectOut(1'b0, 1'b0, "R6");
    resetActive = 1'b0; tick(); expectOut(1'b1, 1'b1, "R6");
    enIn = 1'b0; resetActive = 1'b1; repeat (2) tick();
    expectOut(1'b0, 1'b1, "R1");
    resetActive = 1'b0;

    // R3: underload after blanking plus filter, gate stays on
    enIn = 1'b1; ulFlag = 1'b1;
    countOn(n);
    repeat (UL_BLANK + UL_FILT - 1) tick(); expectOut(1'b1, 1'b1, "R3");
    tick(); expectOut(1'b1, 1'b0, "R3");
    ulFlag = 1'b0; tick(); expectOut(1'b1, 1'b1, "R3");

    // R9: off-forcing fault over underload
    ulFlag = 1'b1; repeat (UL_FILT) tick(); expectOut(1'b1, 1'b0, "R3");
    ocFlag = 1'b1; repeat (OC_FILT) tick(); expectOut(1'b0, 1'b0, "R9");
    ocFlag = 1'b0; repeat (2) tick(); expectOut(1'b0, 1'b0, "R9");

    // R10: blanking restarts on a new turn-on
    enIn = 1'b0; repeat (2) tick(); enIn = 1'b1;
    countOn(n);
    repeat (UL_BLANK + UL_FILT - 1) tick(); expectOut(1'b1, 1'b1, "R10");
    tick(); expectOut(1'b1, 0, "R10");
    ulFlag = 1'b0;

    // R11: enable dropped mid-delay abandons the turn-on
    enIn = 1'b0; repeat (3) tick(); enIn = 1'b1;
    repeat (2) tick(); expectOut(1'b0, 1'b1, "R11");
    enIn = 1'b0; tick(); expectOut(1'b0, 1'b1, "R11");
    enIn = 1'b1;
    countOn(n);
    report("R11", "fresh delay after abort", n, SHORT_DLY + 1);

    // random phase, every cycle compared against the model
    hEn = 0; hOc = 0; hUl = 0; hOt = 0; hCool = 0; hOv = 0; hRst = 0;
    for (int c = 0; c < 4000; c++) begin
      tick();
      if (hEn == 0)   begin enIn = ($urandom_range(99) < 85); hEn = $urandom_range(60, 5); end
      if (hOc == 0)   begin ocFlag = ($urandom_range(99) < 20); hOc = $urandom_range(OC_FILT + 2, 1); end
      if (hUl == 0)   begin ulFlag = ($urandom_range(99) < 40); hUl = $urandom_range(25, 1); end
      if (hOt == 0)   begin otHot = ($urandom_range(99) < 4); hOt = $urandom_range(3, 1); end
      if (hCool == 0) begin otCool = ($urandom_range(99) < 40); hCool = $urandom_range(15, 1); end
      if (hOv == 0)   begin ovFlag = ($urandom_range(99) < 20); hOv = $urandom_range(OV_FILT + 3, 1); end
      if (hRst == 0)  begin resetActive = ($urandom_range(99) < 4); hRst = $urandom_range(6, 1); end
      hEn--; hOc--; hUl--; hOt--; hCool--; hOv--; hRst--;
    end
    finishRun();
  end
endmodule